// File: doc/BRIEF.md
# Branch Resolution Unit

This unit resolves the control-flow instructions of a 64-bit register virtual machine whose programs are measured in 64-bit instruction slots. For each instruction offered to it, the unit decodes the 8-bit opcode and the 4-bit source-selector field. It evaluates conditional compares between the destination value and a second operand, and it resolves unconditional jumps. It also classifies the call and return forms.

The execute stage presents one instruction per cycle with `in_valid`, together with the current program counter and the register operands. One clock later, the unit reports whether the branch is taken and what the next program counter is. Separate flags tell the sequencer about a helper call, a program-local call, a return or an illegal encoding. The caller keeps any call stack and runs any helper.

Top module: `jump_resolver`

## Requirements
- R1: Only opcode class values (opcode bits 2:0) 5 (64-bit compare class) and 6 (32-bit compare class) are resolved. Any other class gives taken 0, next PC = PC + step, and all flags 0.
- R2: Opcode bit 3 selects the second operand. With 0, the 32-bit immediate is sign-extended to 64 bits. With 1, the source register value is used.
- R3: In class 6, compares use only bits 31:0 of both operands. Signed compares take bit 31 as the sign.
- R4: Condition codes are held in opcode bits 7:4. The codes are 1 equal, 5 not equal, 2/3/10/11 unsigned greater/greater-or-equal/less/less-or-equal, and 6/7/12/13 the signed forms in the same order.
- R5: Code 4 is taken when the bitwise AND of the two operands is nonzero.
- R6: A taken compare gives next PC = PC + 1 + the sign-extended 16-bit offset. A branch that is not taken gives next PC = PC + step, where step is 2 when `in_wide` is 1 and 1 otherwise. All PC arithmetic wraps at PC_W bits.
- R7: Code 0 with opcode bit 3 clear is always taken. In class 5 it adds the 16-bit offset. In class 6 it adds the 32-bit immediate, in both cases to PC + 1.
- R8: Code 8 in class 5 with opcode bit 3 clear is a call. Selector 0 raises the helper-by-number flag and selector 2 raises the helper-by-type flag; neither of these is taken, and both give next PC = PC + step. Selector 1 raises the local-call flag, is taken, and gives next PC = PC + 1 + immediate.
- R9: Code 9 in class 5 with opcode bit 3 clear raises the return flag and is not taken.
- R10: The illegal flag is raised, with taken 0, no other flag and next PC = PC + step, in these cases: code 0, 8 or 9 with opcode bit 3 set; code 8 or 9 in class 6; code 8 with a selector above 2; codes 14 and 15.
- R11: Results appear one clock after the cycle in which `in_valid` is high, with `out_valid` high for that one cycle. While `in_valid` is low, the result outputs hold their values. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_opcode | input | 8 | Opcode: condition bits 7:4, operand select bit 3, class bits 2:0 |
| in_srcsel | input | 4 | Source-selector field (call kind for code 8) |
| in_offset | input | OFF_W | Signed jump offset in slots |
| in_imm | input | IMM_W | Signed immediate |
| in_dst | input | DATA_W | Destination register value |
| in_src | input | DATA_W | Source register value |
| in_pc | input | PC_W | Current slot address |
| in_wide | input | 1 | Current instruction spans two slots |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Control transfer taken |
| out_next_pc | output | PC_W | Next slot address |
| out_call_helper | output | 1 | Helper call by number |
| out_call_local | output | 1 | Program-local call |
| out_call_typed | output | 1 | Helper call by type identifier |
| out_exit | output | 1 | Return |
| out_illegal | output | 1 | Illegal encoding |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid` high. The bench drives inputs on the falling edge and compares all result outputs against its own model at the next falling edge, which is half a period after the result registers load. Hold behaviour is checked one falling edge after an idle cycle in which the inputs were changed, so that any unwanted load would already be visible.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

  localparam logic [3:0] CC_ALWAYS = 4'h0;
  localparam logic [3:0] CC_EQ     = 4'h1;
  localparam logic [3:0] CC_UGT    = 4'h2;
  localparam logic [3:0] CC_UGE    = 4'h3;
  localparam logic [3:0] CC_ANY    = 4'h4;
  localparam logic [3:0] CC_NE     = 4'h5;
  localparam logic [3:0] CC_SGT    = 4'h6;
  localparam logic [3:0] CC_SGE    = 4'h7;
  localparam logic [3:0] CC_CALL   = 4'h8;
  localparam logic [3:0] CC_RET    = 4'h9;
  localparam logic [3:0] CC_ULT    = 4'ha;
  localparam logic [3:0] CC_ULE    = 4'hb;
  localparam logic [3:0] CC_SLT    = 4'hc;
  localparam logic [3:0] CC_SLE    = 4'hd;

  typedef enum logic [3:0] {
    K_NONE, K_COND, K_GO_OFF, K_GO_IMM,
    K_CALL_ID, K_CALL_LOCAL, K_CALL_TYPE, K_RET, K_BAD
  } kind_e;
endpackage

// File: rtl/jr_decode.sv
module jr_decode
  import jr_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [3:0] srcsel,
  output kind_e      kind,
  output logic       narrow
);
  logic [2:0] cls;
  logic [3:0] code;
  logic       use_reg;

  assign cls     = opcode[2:0];
  assign code    = opcode[7:4];
  assign use_reg = opcode[3];
  assign narrow  = (cls == CLS_NARROW);

  always_comb begin
    kind = K_NONE;
    if (cls == CLS_WIDE || cls == CLS_NARROW) begin
      unique case (code)
        CC_ALWAYS: kind = use_reg ? K_BAD : (narrow ? K_GO_IMM : K_GO_OFF);
        CC_CALL: begin
          if (use_reg || narrow)   kind = K_BAD;
          else if (srcsel == 4'd0) kind = K_CALL_ID;
          else if (srcsel == 4'd1) kind = K_CALL_LOCAL;
          else if (srcsel == 4'd2) kind = K_CALL_TYPE;
          else                     kind = K_BAD;
        end
        CC_RET:     kind = (use_reg || narrow) ? K_BAD : K_RET;
        4'he, 4'hf: kind = K_BAD;
        default:    kind = K_COND;
      endcase
    end
  end
endmodule

// File: rtl/jr_compare.sv
module jr_compare
  import jr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   code,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  logic signed [W-1:0] sa;
  logic signed [W-1:0] sb;

  assign sa = $signed(a);
  assign sb = $signed(b);

  always_comb begin
    unique case (code)
      CC_EQ:   hit = (a == b);
      CC_NE:   hit = (a != b);
      CC_UGT:  hit = (a >  b);
      CC_UGE:  hit = (a >= b);
      CC_ULT:  hit = (a <  b);
      CC_ULE:  hit = (a <= b);
      CC_SGT:  hit = (sa >  sb);
      CC_SGE:  hit = (sa >= sb);
      CC_SLT:  hit = (sa <  sb);
      CC_SLE:  hit = (sa <= sb);
      CC_ANY:  hit = |(a & b);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
  import jr_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int PC_W     = 32,
  parameter int OFF_W    = 16,
  parameter int IMM_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_opcode,
  input  logic [3:0]        in_srcsel,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic [PC_W-1:0]   in_pc,
  input  logic              in_wide,
  output logic              out_valid,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_call_helper,
  output logic              out_call_local,
  output logic              out_call_typed,
  output logic              out_exit,
  output logic              out_illegal
);
  localparam int NUM_CMP = 2;

  kind_e             kind;
  logic              narrow;
  logic [DATA_W-1:0] operand;
  logic [NUM_CMP-1:0] hits;
  logic              hit;

  logic [PC_W-1:0]   pc_lin, pc_seq, off_pc, imm_pc, step_amt;
  logic              taken_d;
  logic [PC_W-1:0]   next_d;
  logic [4:0]        flags_d;

  jr_decode u_dec (
    .opcode (in_opcode),
    .srcsel (in_srcsel),
    .kind   (kind),
    .narrow (narrow)
  );

  assign operand = in_opcode[3] ? in_src : DATA_W'($signed(in_imm));

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    localparam int CW = (g == 0) ? DATA_W : NARROW_W;
    jr_compare #(.W(CW)) u_cmp (
      .code (in_opcode[7:4]),
      .a    (in_dst[CW-1:0]),
      .b    (operand[CW-1:0]),
      .hit  (hits[g])
    );
  end

  assign hit      = narrow ? hits[1] : hits[0];
  assign step_amt = in_wide ? PC_W'(2) : PC_W'(1);
  assign pc_lin   = in_pc + PC_W'(1);
  assign pc_seq   = in_pc + step_amt;
  assign off_pc   = PC_W'($signed(in_offset));
  assign imm_pc   = PC_W'($signed(in_imm));

  // next-state logic
  always_comb begin
    taken_d = 1'b0;
    next_d  = pc_seq;
    flags_d = 5'b0; // {helper, local, typed, exit, illegal}
    unique case (kind)
      K_COND: begin
        taken_d = hit;
        if (hit) next_d = pc_lin + off_pc;
      end
      K_GO_OFF: begin
        taken_d = 1'b1;
        next_d  = pc_lin + off_pc;
      end
      K_GO_IMM: begin
        taken_d = 1'b1;
        next_d  = pc_lin + imm_pc;
      end
      K_CALL_LOCAL: begin
        taken_d    = 1'b1;
        next_d     = pc_lin + imm_pc;
        flags_d[3] = 1'b1;
      end
      K_CALL_ID:   flags_d[4] = 1'b1;
      K_CALL_TYPE: flags_d[2] = 1'b1;
      K_RET:       flags_d[1] = 1'b1;
      K_BAD:       flags_d[0] = 1'b1;
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_taken       <= 1'b0;
      out_next_pc     <= '0;
      out_call_helper <= 1'b0;
      out_call_local  <= 1'b0;
      out_call_typed  <= 1'b0;
      out_exit        <= 1'b0;
      out_illegal     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken       <= taken_d;
        out_next_pc     <= next_d;
        out_call_helper <= flags_d[4];
        out_call_local  <= flags_d[3];
        out_call_typed  <= flags_d[2];
        out_exit        <= flags_d[1];
        out_illegal     <= flags_d[0];
      end
    end
  end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_next_pc) && $stable(out_taken) && $stable(out_illegal)));
  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_call_helper, out_call_local, out_call_typed, out_exit, out_illegal}));
  a_r10_illegal_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !out_taken);
  a_r9_exit_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_exit |-> !out_taken);
  a_r8_local_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_call_local |-> out_taken);
  a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_opcode[2]) |=> (!out_taken && out_next_pc == $past(in_pc) + PC_W'($past(in_wide) ? 2 : 1)));
endmodule

// File: tb/jump_resolver_test.sv
module jump_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_opcode;
  logic [3:0]  in_srcsel;
  logic [15:0] in_offset;
  logic [31:0] in_imm;
  logic [63:0] in_dst, in_src;
  logic [31:0] in_pc;
  logic        in_wide;
  logic        out_valid, out_taken;
  logic [31:0] out_next_pc;
  logic        out_call_helper, out_call_local, out_call_typed, out_exit, out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  jump_resolver uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_srcsel(in_srcsel), .in_offset(in_offset), .in_imm(in_imm),
    .in_dst(in_dst), .in_src(in_src), .in_pc(in_pc), .in_wide(in_wide),
    .out_valid(out_valid), .out_taken(out_taken), .out_next_pc(out_next_pc),
    .out_call_helper(out_call_helper), .out_call_local(out_call_local),
    .out_call_typed(out_call_typed), .out_exit(out_exit), .out_illegal(out_illegal)
  );

  // packed result: {taken, next_pc[31:0], helper, local, typed, exit, illegal}
  function automatic logic [37:0] model(input logic [7:0] opc, input logic [3:0] ss,
      input logic [15:0] off, input logic [31:0] imm, input logic [63:0] dst,
      input logic [63:0] src, input logic [31:0] pc, input logic wide);
    logic [2:0]  cls  = opc[2:0];
    logic [3:0]  code = opc[7:4];
    logic        x    = opc[3];
    logic [31:0] seq  = pc + (wide ? 32'd2 : 32'd1);
    logic [31:0] lin  = pc + 32'd1;
    logic [31:0] t_off = lin + {{16{off[15]}}, off};
    logic [31:0] t_imm = lin + imm;
    logic [63:0] b, ua, ub;
    logic signed [63:0] sa, sb;
    logic c;
    if (cls != 3'd5 && cls != 3'd6) return {1'b0, seq, 5'b00000};
    b = x ? src : {{32{imm[31]}}, imm};
    if (cls == 3'd6) begin
      ua = {32'd0, dst[31:0]}; ub = {32'd0, b[31:0]};
      sa = {{32{dst[31]}}, dst[31:0]}; sb = {{32{b[31]}}, b[31:0]};
    end else begin
      ua = dst; ub = b; sa = dst; sb = b;
    end
    case (code)
      4'h0: return x ? {1'b0, seq, 5'b00001} : {1'b1, (cls == 3'd6) ? t_imm : t_off, 5'b0};
      4'h8: begin
        if (x || cls == 3'd6 || ss > 4'd2) return {1'b0, seq, 5'b00001};
        if (ss == 4'd0) return {1'b0, seq, 5'b10000};
        if (ss == 4'd1) return {1'b1, t_imm, 5'b01000};
        return {1'b0, seq, 5'b00100};
      end
      4'h9: return (x || cls == 3'd6) ? {1'b0, seq, 5'b00001} : {1'b0, seq, 5'b00010};
      4'he, 4'hf: return {1'b0, seq, 5'b00001};
      4'h1: c = (ua == ub);
      4'h5: c = (ua != ub);
      4'h2: c = (ua > ub);
      4'h3: c = (ua >= ub);
      4'ha: c = (ua < ub);
      4'hb: c = (ua <= ub);
      4'h6: c = (sa > sb);
      4'h7: c = (sa >= sb);
      4'hc: c = (sa < sb);
      4'hd: c = (sa <= sb);
      default: c = |(ua & ub);
    endcase
    return {c, c ? t_off : seq, 5'b0};
  endfunction

  function automatic logic [37:0] got();
    return {out_taken, out_next_pc, out_call_helper, out_call_local, out_call_typed, out_exit, out_illegal};
  endfunction

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // entered just after a falling edge
  task automatic run(input string tag, input logic [7:0] opc, input logic [3:0] ss,
      input logic [15:0] off, input logic [31:0] imm, input logic [63:0] dst,
      input logic [63:0] src, input logic [31:0] pc, input logic wide);
    logic [37:0] exp;
    in_valid = 1'b1; in_opcode = opc; in_srcsel = ss; in_offset = off; in_imm = imm;
    in_dst = dst; in_src = src; in_pc = pc; in_wide = wide;
    exp = model(opc, ss, off, imm, dst, src, pc, wide);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {got(), out_valid}, {exp, 1'b1});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [37:0] held;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_valid = 0; in_opcode = 0; in_srcsel = 0; in_offset = 0;
    in_imm = 0; in_dst = 0; in_src = 0; in_pc = 0; in_wide = 0;
    repeat (3) @(negedge clk);
    check("R11 reset", {got(), out_valid}, 39'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R1 other class", 8'h14, 0, 16'd4, 0, 5, 5, 32'd100, 0);
    check("R1 literal", got(), {1'b0, 32'd101, 5'b0});
    run("R1 class7 wide", 8'h17, 0, 16'd4, 0, 5, 5, 32'd100, 1);
    run("R2 imm sign-extend", 8'h15, 0, 16'd7, 32'hFFFF_FFFB, 64'hFFFF_FFFF_FFFF_FFFB, 0, 32'd20, 0);
    check("R2 literal", got(), {1'b1, 32'd28, 5'b0});
    run("R2 register operand", 8'h1d, 0, 16'd7, 32'h0, 64'h1234_0000_0000_0001, 64'h1234_0000_0000_0001, 32'd20, 0);
    run("R3 narrow eq upper differs", 8'h1e, 0, 16'd3, 0, 64'hAAAA_0000_0000_1234, 64'h5555_0000_0000_1234, 32'd50, 0);
    check("R3 literal", got(), {1'b1, 32'd54, 5'b0});
    run("R3 wide eq upper differs", 8'h1d, 0, 16'd3, 0, 64'hAAAA_0000_0000_1234, 64'h5555_0000_0000_1234, 32'd50, 0);
    run("R3 narrow signed", 8'h6e, 0, 16'd3, 0, 64'h0000_0000_8000_0000, 64'd1, 32'd50, 0);
    run("R4 unsigned gt", 8'h2d, 0, 16'd9, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 0);
    run("R4 signed gt", 8'h6d, 0, 16'd9, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 0);
    check("R4 literal", got(), {1'b0, 32'd1, 5'b0});
    run("R4 sle equal", 8'hdd, 0, 16'd9, 0, 64'd7, 64'd7, 32'd0, 0);
    run("R5 mask hit", 8'h4d, 0, 16'd2, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 32'd9, 0);
    run("R5 mask miss", 8'h4d, 0, 16'd2, 0, 64'h0F, 64'hF0, 32'd9, 0);
    run("R6 wide step", 8'h1d, 0, 16'd2, 0, 64'd1, 64'd2, 32'd9, 1);
    check("R6 literal", got(), {1'b0, 32'd11, 5'b0});
    run("R6 backward", 8'h15, 0, 16'hFFFD, 32'd0, 64'd0, 0, 32'd10, 0);
    check("R6 literal back", got(), {1'b1, 32'd8, 5'b0});
    run("R7 jump offset", 8'h05, 0, 16'd40, 32'd900, 0, 0, 32'd10, 0);
    check("R7 literal", got(), {1'b1, 32'd51, 5'b0});
    run("R7 jump imm", 8'h06, 0, 16'd40, 32'd900, 0, 0, 32'd10, 0);
    check("R7 literal imm", got(), {1'b1, 32'd911, 5'b0});
    run("R8 helper id", 8'h85, 0, 0, 32'd12, 0, 0, 32'd30, 0);
    check("R8 literal helper", got(), {1'b0, 32'd31, 5'b10000});
    run("R8 local call", 8'h85, 1, 0, 32'hFFFF_FFF0, 0, 0, 32'd30, 0);
    check("R8 literal local", got(), {1'b1, 32'd15, 5'b01000});
    run("R8 typed helper", 8'h85, 2, 0, 32'd77, 0, 0, 32'd30, 0);
    run("R9 return", 8'h95, 0, 0, 0, 0, 0, 32'd30, 0);
    check("R9 literal", got(), {1'b0, 32'd31, 5'b00010});
    run("R10 call selector 3", 8'h85, 3, 0, 0, 0, 0, 32'd30, 0);
    check("R10 literal", got(), {1'b0, 32'd31, 5'b00001});
    run("R10 return narrow", 8'h96, 0, 0, 0, 0, 0, 32'd30, 0);
    run("R10 jump register", 8'h0d, 0, 16'd5, 0, 0, 0, 32'd30, 0);
    run("R10 code 14", 8'he5, 0, 16'd5, 0, 0, 0, 32'd30, 1);

    held = got();
    in_opcode = 8'h05; in_offset = 16'd100; in_pc = 32'd7777; in_srcsel = 4'd1;
    @(negedge clk);
    check("R11 hold", {got(), out_valid}, {held, 1'b0});

    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  opc;
      logic [63:0] d, s;
      opc = 8'($urandom);
      if ($urandom_range(3) != 0) opc[2:0] = $urandom_range(1) ? 3'd5 : 3'd6;
      d = {$urandom, $urandom};
      s = {$urandom, $urandom};
      case ($urandom_range(3))
        0: s = d;
        1: s[31:0] = d[31:0];
        default: ;
      endcase
      run("R4 random", opc, 4'($urandom_range(3)), 16'($urandom), $urandom, d, s, $urandom, 1'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule